// File: doc/BRIEF.md
# Receive Fill-Level Watcher with Hysteretic RTS

This block sits beside a receive FIFO and turns its occupancy count into three signals. A trigger flag, with a one-cycle rising-edge event, tells interrupt logic that enough data has arrived. A flow-delay status flag shows that the FIFO has reached a second, higher threshold. A registered, active-low RTS pin throttles the far-end transmitter.

When hardware flow control is on, RTS is withdrawn as soon as the fill level reaches the flow-delay threshold. It is offered again only after the level has drained to at least the hysteresis distance (4 by default) below that threshold. A flow-delay threshold below the minimum (4 by default) turns the flow-delay feature off completely. When hardware flow control is off, RTS simply mirrors a software request bit.

Both thresholds live in a small configuration register, loaded together by a single write strobe. The trigger threshold resets to 32 and the flow-delay threshold resets to 0, which means disabled. All three outputs are registered, so each one reflects the inputs sampled at the previous clock edge.

Top module: `rx_fill_watch`

## Requirements
- R1: While reset is asserted and after its release with idle inputs, rts_n is 1 and trig_flag, trig_evt and fdel_flag are 0.
- R2: Out of reset the trigger threshold is 32. A fill level of 31 leaves trig_flag at 0, and a level of 32 sets it one cycle later.
- R3: With a non-zero trigger threshold T, trig_flag is 1 in the cycle after a sample where the level is at least T, and 0 in the cycle after a sample where the level is below T.
- R4: A trigger threshold of 0 keeps trig_flag and trig_evt at 0 for every fill level, including 63.
- R5: trig_evt is 1 for exactly one cycle, in the cycle where trig_flag goes from 0 to 1. It stays 0 while trig_flag remains 1.
- R6: With a flow-delay threshold F of 4 or more, fdel_flag is 1 in the cycle after a sample where the level is at least F, and 0 otherwise. It does not affect trig_flag or trig_evt.
- R7: A flow-delay threshold below 4 keeps fdel_flag at 0. With flow control on, it also keeps RTS asserted (rts_n = 0) at every fill level.
- R8: With flow control on and F of 4 or more, rts_n is 1 in the cycle after a sample where the level is at least F.
- R9: With flow control on and F of 4 or more, rts_n returns to 0 only after a sample where the level is at most F-4. For levels strictly between F-4 and F, rts_n holds its value.
- R10: With flow control off, rts_n equals the inverse of sw_rts sampled at the previous edge (sw_rts = 1 requests RTS, giving rts_n = 0).
- R11: A cycle with cfg_we = 1 loads trig_lvl and fdel_lvl together. The new thresholds govern the comparison at the following clock edge, so the outputs reflect them two cycles after the load is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fill_lvl | input | 6 | Current receive FIFO occupancy |
| cfg_we | input | 1 | Load strobe for both thresholds |
| trig_lvl | input | 6 | Trigger threshold to load (0 disables) |
| fdel_lvl | input | 6 | Flow-delay threshold to load (below 4 disables) |
| fc_mode_en | input | 1 | Hardware flow control enable |
| sw_rts | input | 1 | Software RTS request, 1 asks for RTS |
| rts_n | output | 1 | Registered active-low RTS pin |
| trig_flag | output | 1 | Fill level at or above trigger threshold |
| trig_evt | output | 1 | One-cycle pulse on trig_flag rising |
| fdel_flag | output | 1 | Fill level at or above flow-delay threshold |

## Verification
The bench builds the block with its default parameters: a 6-bit level, a hysteresis distance of 4, a minimum flow-delay threshold of 4 and a trigger reset value of 32. At these values every fill level from 0 to 63 is reachable with a single input. This lets the bench hit the exact threshold edges: the reset trigger value at 31 and 32, a flow-delay threshold of 20 with its hold band from 17 to 19, the smallest enabled flow-delay value of 4 whose resume point is level 0, and the disabled value 3. Each expected output comes from a cycle model of the requirements, and a monitor compares it one edge after the inputs are applied.

// File: rtl/rxlvl_pkg.sv
package rxlvl_pkg;

  // Decision taken by the RTS controller for the next cycle.
  typedef enum logic [2:0] {
    RTS_FOLLOW_SW = 3'd0,
    RTS_FREE      = 3'd1,
    RTS_THROTTLE  = 3'd2,
    RTS_RESUME    = 3'd3,
    RTS_HOLD      = 3'd4
  } rts_action_e;

endpackage

// File: rtl/rxlvl_cfg.sv
module rxlvl_cfg #(
  parameter int LVL_W    = 6,
  parameter int TRIG_RST = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [LVL_W-1:0] trig_in,
  input  logic [LVL_W-1:0] fdel_in,
  output logic [LVL_W-1:0] trig_q,
  output logic [LVL_W-1:0] fdel_q
);

  localparam logic [LVL_W-1:0] TRIG_INIT = LVL_W'(TRIG_RST);

  logic [LVL_W-1:0] trig_d;
  logic [LVL_W-1:0] fdel_d;

  always_comb begin
    trig_d = trig_q;
    fdel_d = fdel_q;
    if (cfg_we) begin
      trig_d = trig_in;
      fdel_d = fdel_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q <= TRIG_INIT;
      fdel_q <= '0;
    end else if (cfg_we) begin
      trig_q <= trig_d;
      fdel_q <= fdel_d;
    end
  end

endmodule

// File: rtl/rxlvl_thresh.sv
module rxlvl_thresh #(
  parameter int LVL_W  = 6,
  parameter int MIN_EN = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] level,
  input  logic [LVL_W-1:0] thr,
  output logic             hit,
  output logic             flag_q
);

  localparam logic [LVL_W-1:0] THR_MIN = LVL_W'(MIN_EN);

  logic thr_en;
  logic flag_d;

  always_comb begin
    thr_en = (thr >= THR_MIN);
    hit    = thr_en && (level >= thr);
    flag_d = hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

endmodule

// File: rtl/rxlvl_edge.sv
module rxlvl_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic d_next,
  input  logic d_now,
  output logic rise_q
);

  logic rise_d;

  always_comb rise_d = d_next && !d_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rise_q <= 1'b0;
    else        rise_q <= rise_d;
  end

endmodule

// File: rtl/rxlvl_rts.sv
module rxlvl_rts
  import rxlvl_pkg::*;
#(
  parameter int LVL_W  = 6,
  parameter int HYST   = 4,
  parameter int MIN_FD = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] level,
  input  logic [LVL_W-1:0] fdel_q,
  input  logic             fd_hit,
  input  logic             fc_mode_en,
  input  logic             sw_rts,
  output logic             rts_n
);

  localparam int               EXT_W    = LVL_W + 1;
  localparam logic [EXT_W-1:0] HYST_EXT = EXT_W'(HYST);
  localparam logic [LVL_W-1:0] FD_MIN   = LVL_W'(MIN_FD);

  rts_action_e      act;
  logic             fd_en;
  logic [EXT_W-1:0] lvl_plus;
  logic             below_band;
  logic             rts_on_q;
  logic             rts_on_d;

  always_comb begin
    fd_en      = (fdel_q >= FD_MIN);
    lvl_plus   = {1'b0, level} + HYST_EXT;
    below_band = !fd_hit && (lvl_plus <= {1'b0, fdel_q});
    if (!fc_mode_en)     act = RTS_FOLLOW_SW;
    else if (!fd_en)     act = RTS_FREE;
    else if (fd_hit)     act = RTS_THROTTLE;
    else if (below_band) act = RTS_RESUME;
    else                 act = RTS_HOLD;
  end

  always_comb begin
    unique case (act)
      RTS_FOLLOW_SW: rts_on_d = sw_rts;
      RTS_FREE:      rts_on_d = 1'b1;
      RTS_THROTTLE:  rts_on_d = 1'b0;
      RTS_RESUME:    rts_on_d = 1'b1;
      default:       rts_on_d = rts_on_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rts_on_q <= 1'b0;
    else        rts_on_q <= rts_on_d;
  end

  assign rts_n = !rts_on_q;

endmodule

// File: rtl/rx_fill_watch.sv
module rx_fill_watch #(
  parameter int LVL_W    = 6,
  parameter int HYST     = 4,
  parameter int MIN_FD   = 4,
  parameter int TRIG_RST = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] fill_lvl,
  input  logic             cfg_we,
  input  logic [LVL_W-1:0] trig_lvl,
  input  logic [LVL_W-1:0] fdel_lvl,
  input  logic             fc_mode_en,
  input  logic             sw_rts,
  output logic             rts_n,
  output logic             trig_flag,
  output logic             trig_evt,
  output logic             fdel_flag
);

  logic [LVL_W-1:0] trig_q;
  logic [LVL_W-1:0] fdel_q;
  logic             trig_hit;
  logic             fd_hit;

  rxlvl_cfg #(.LVL_W(LVL_W), .TRIG_RST(TRIG_RST)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we),
    .trig_in(trig_lvl), .fdel_in(fdel_lvl),
    .trig_q(trig_q), .fdel_q(fdel_q)
  );

  rxlvl_thresh #(.LVL_W(LVL_W), .MIN_EN(1)) u_trig (
    .clk(clk), .rst_n(rst_n), .level(fill_lvl), .thr(trig_q),
    .hit(trig_hit), .flag_q(trig_flag)
  );

  rxlvl_thresh #(.LVL_W(LVL_W), .MIN_EN(MIN_FD)) u_fdel (
    .clk(clk), .rst_n(rst_n), .level(fill_lvl), .thr(fdel_q),
    .hit(fd_hit), .flag_q(fdel_flag)
  );

  rxlvl_edge u_evt (
    .clk(clk), .rst_n(rst_n), .d_next(trig_hit), .d_now(trig_flag),
    .rise_q(trig_evt)
  );

  rxlvl_rts #(.LVL_W(LVL_W), .HYST(HYST), .MIN_FD(MIN_FD)) u_rts (
    .clk(clk), .rst_n(rst_n), .level(fill_lvl), .fdel_q(fdel_q),
    .fd_hit(fd_hit), .fc_mode_en(fc_mode_en), .sw_rts(sw_rts),
    .rts_n(rts_n)
  );

endmodule

// File: rtl/rx_fill_watch_chk.sv
module rx_fill_watch_chk #(
  parameter int LVL_W  = 6,
  parameter int HYST   = 4,
  parameter int MIN_FD = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [LVL_W-1:0] fill_lvl,
  input logic             fc_mode_en,
  input logic             sw_rts,
  input logic [LVL_W-1:0] trig_q,
  input logic [LVL_W-1:0] fdel_q,
  input logic             rts_n,
  input logic             trig_flag,
  input logic             trig_evt,
  input logic             fdel_flag
);

  localparam int EXT_W = LVL_W + 1;

  logic fd_on;
  logic in_band;

  always_comb begin
    fd_on   = (int'(fdel_q) >= MIN_FD);
    in_band = (fill_lvl < fdel_q) &&
              (({1'b0, fill_lvl} + EXT_W'(HYST)) > {1'b0, fdel_q});
  end

  assert_evt_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    trig_evt |-> (trig_flag && !$past(trig_flag)));

  assert_trig_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_q == '0) |=> (!trig_flag && !trig_evt));

  assert_fdel_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !fd_on |=> !fdel_flag);

  assert_throttle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fc_mode_en && fd_on && (fill_lvl >= fdel_q)) |=> rts_n);

  assert_hold_band_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fc_mode_en && fd_on && in_band) |=> $stable(rts_n));

  assert_sw_follow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !fc_mode_en |=> (rts_n == !$past(sw_rts)));

endmodule

bind rx_fill_watch rx_fill_watch_chk #(.LVL_W(LVL_W), .HYST(HYST), .MIN_FD(MIN_FD)) u_chk (
  .clk(clk), .rst_n(rst_n), .fill_lvl(fill_lvl), .fc_mode_en(fc_mode_en),
  .sw_rts(sw_rts), .trig_q(trig_q), .fdel_q(fdel_q), .rts_n(rts_n),
  .trig_flag(trig_flag), .trig_evt(trig_evt), .fdel_flag(fdel_flag)
);

// File: tb/sim_rx_fill_watch.sv
module sim_rx_fill_watch;

  logic       clk;
  logic       rst_n;
  logic [5:0] fill_lvl;
  logic       cfg_we;
  logic [5:0] trig_lvl;
  logic [5:0] fdel_lvl;
  logic       fc_mode_en;
  logic       sw_rts;
  logic       rts_n;
  logic       trig_flag;
  logic       trig_evt;
  logic       fdel_flag;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  typedef struct {
    logic  rn;
    logic  tf;
    logic  te;
    logic  ff;
    string tag;
  } exp_t;

  exp_t sb[$];

  // bench model state
  int   m_trig;
  int   m_fdel;
  logic m_tf;
  logic m_on;

  rx_fill_watch u0 (
    .clk(clk), .rst_n(rst_n), .fill_lvl(fill_lvl), .cfg_we(cfg_we),
    .trig_lvl(trig_lvl), .fdel_lvl(fdel_lvl), .fc_mode_en(fc_mode_en),
    .sw_rts(sw_rts), .rts_n(rts_n), .trig_flag(trig_flag),
    .trig_evt(trig_evt), .fdel_flag(fdel_flag)
  );

  initial clk = 0;
  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input string what, input logic got, input logic exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s got=%b exp=%b", tag, what, got, exp);
    end
  endtask

  // driver: apply one cycle of inputs and queue the outputs they must yield
  task automatic step(input int lvl, input logic fc, input logic sw,
                      input logic we, input int tl, input int fl, input string tag);
    exp_t e;
    logic nt, nf, nr;
    @(negedge clk);
    fill_lvl = 6'(lvl); fc_mode_en = fc; sw_rts = sw;
    cfg_we = we; trig_lvl = 6'(tl); fdel_lvl = 6'(fl);
    nt = (m_trig != 0) && (lvl >= m_trig);
    nf = (m_fdel >= 4) && (lvl >= m_fdel);
    if (!fc)               nr = sw;
    else if (m_fdel < 4)   nr = 1'b1;
    else if (lvl >= m_fdel) nr = 1'b0;
    else if (lvl + 4 <= m_fdel) nr = 1'b1;
    else                   nr = m_on;
    e.rn = !nr; e.tf = nt; e.te = nt && !m_tf; e.ff = nf; e.tag = tag;
    sb.push_back(e);
    m_tf = nt; m_on = nr;
    if (we) begin m_trig = tl; m_fdel = fl; end
  endtask

  // monitor
  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      chk(e.tag, "rts_n", rts_n, e.rn);
      chk(e.tag, "trig_flag", trig_flag, e.tf);
      chk(e.tag, "trig_evt", trig_evt, e.te);
      chk(e.tag, "fdel_flag", fdel_flag, e.ff);
    end
  end

  initial begin
    #(5ns * 20000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; fill_lvl = 0; cfg_we = 0; trig_lvl = 0; fdel_lvl = 0;
    fc_mode_en = 0; sw_rts = 0;
    m_trig = 32; m_fdel = 0; m_tf = 0; m_on = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "rts_n in reset", rts_n, 1'b1);
    chk("R1", "trig_flag in reset", trig_flag, 1'b0);
    chk("R1", "trig_evt in reset", trig_evt, 1'b0);
    chk("R1", "fdel_flag in reset", fdel_flag, 1'b0);
    @(negedge clk); rst_n = 1;
    step(0, 0, 0, 0, 0, 0, "R1");
    // software RTS with flow control off
    step(0, 0, 1, 0, 0, 0, "R10");
    step(0, 0, 1, 0, 0, 0, "R10");
    step(0, 0, 0, 0, 0, 0, "R10");
    // reset trigger threshold 32
    step(31, 0, 0, 0, 0, 0, "R2");
    step(32, 0, 0, 0, 0, 0, "R2");
    step(40, 0, 0, 0, 0, 0, "R5");
    step(63, 0, 0, 0, 0, 0, "R5");
    step(10, 0, 0, 0, 0, 0, "R3");
    // load trigger 8, flow delay 20
    step(10, 0, 0, 1, 8, 20, "R11");
    step(10, 0, 0, 0, 0, 0, "R11");
    step(7, 0, 0, 0, 0, 0, "R3");
    step(8, 0, 0, 0, 0, 0, "R3");
    step(9, 0, 0, 0, 0, 0, "R5");
    step(20, 0, 1, 0, 0, 0, "R6");
    step(19, 0, 1, 0, 0, 0, "R6");
    // hysteresis with flow control on, threshold 20
    step(10, 1, 0, 0, 0, 0, "R9");
    step(20, 1, 0, 0, 0, 0, "R8");
    step(19, 1, 0, 0, 0, 0, "R9");
    step(17, 1, 0, 0, 0, 0, "R9");
    step(16, 1, 0, 0, 0, 0, "R9");
    step(19, 1, 0, 0, 0, 0, "R9");
    step(25, 1, 0, 0, 0, 0, "R8");
    step(18, 1, 1, 0, 0, 0, "R9");
    // trigger threshold 0 and flow delay 3
    step(18, 1, 0, 1, 0, 3, "R4");
    step(63, 1, 0, 0, 0, 0, "R4");
    step(63, 1, 0, 0, 0, 0, "R7");
    step(2, 1, 0, 0, 0, 0, "R7");
    // smallest enabled flow delay 4
    step(2, 1, 0, 1, 1, 4, "R11");
    step(4, 1, 0, 0, 0, 0, "R8");
    step(1, 1, 0, 0, 0, 0, "R9");
    step(0, 1, 0, 0, 0, 0, "R9");
    step(3, 1, 0, 0, 0, 0, "R9");
    step(0, 0, 0, 0, 0, 0, "R10");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule